// File: doc/BRIEF.md
# Burst column address generator

This block sequences the column addresses of one memory burst. A column command supplies a start column, a three-bit length code, a wrap-order select and a read/write flag. From the next clock on the block presents one column per cycle with a valid strobe. It also raises a flag on the final beat. The caller feeds the column straight to the array's column decoder. The row, bank and data logic sit outside this block.

Two wrap orders are offered. The sequential order counts the low bits upward and wraps them modulo the burst length. The interleaved order XORs the beat index into the low bits of the start column. A full-row code runs sequentially across every column of the row and repeats until something ends it. Any burst can be cut short by a stop input or replaced by a new command on any clock. A single-write mode setting clamps write bursts to one beat while reads keep their programmed length. A reserved length code is run as one beat and leaves a sticky error flag.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is applied and after it, until the first command, `col_valid_o`, `last_beat_o` and `bad_len_o` are low.
- R2: A command sampled on a rising edge makes `col_valid_o` high and `col_o` equal to that command's start column from that edge on.
- R3: Length code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `last_beat_o` is high exactly with the final beat, and `col_valid_o` falls on the edge after the final beat unless a command arrives.
- R4: With `wrap_il_i`=0 (sequential), beat n carries the start column with its low log2(length) bits replaced by (start + n) modulo the length. The upper bits stay unchanged.
- R5: With `wrap_il_i`=1 (interleaved), beat n carries the start column with its low log2(length) bits XORed with n. For example, start 1 in a 4-beat burst gives 1,0,3,2.
- R6: Length code 111 (full row) steps sequentially through all 2^COL_W columns from the start column and wraps without end. `last_beat_o` is never high in this mode, and `wrap_il_i` has no effect.
- R7: `stop_i` sampled high ends the burst, so `col_valid_o` is low from that edge on. A command on the same edge takes precedence over the stop.
- R8: When `single_wr_i`=1, a write command (`cmd_write_i`=1) gives a one-beat burst whatever its length code. Read commands keep their programmed length.
- R9: A command arriving during a burst abandons it. The new burst's first column appears on the following cycle.
- R10: Length codes 100, 101 and 110 run a one-beat burst and set `bad_len_o` from the next edge. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Column command present this cycle |
| cmd_write_i | input | 1 | Command is a write (1) or read (0) |
| start_col_i | input | COL_W | Start column of the command |
| len_code_i | input | 3 | Burst length code |
| wrap_il_i | input | 1 | 1 selects interleaved order, 0 sequential |
| single_wr_i | input | 1 | Single-write mode enable |
| stop_i | input | 1 | Burst stop |
| col_o | output | COL_W | Current column |
| col_valid_o | output | 1 | `col_o` holds a burst beat |
| last_beat_o | output | 1 | Current beat is the final one |
| bad_len_o | output | 1 | Sticky reserved-length flag |

## Verification
Every result is due one rising edge after the input that causes it. The first column appears on the edge that samples the command, and each later beat one edge after the previous one. The valid strobe falls on the edge after the final beat or after a sampled stop, and the error flag rises on the edge that samples a reserved code. The bench applies inputs at the falling edge and advances its own reference model by exactly one edge at the same time. At the next falling edge it compares the outputs with that model, so each comparison looks at the value due one edge after the stimulus.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;

  // length codes; the three unlisted values are reserved
  localparam logic [LEN_CODE_W-1:0] LEN_1   = 3'b000;
  localparam logic [LEN_CODE_W-1:0] LEN_2   = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LEN_4   = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LEN_8   = 3'b011;
  localparam logic [LEN_CODE_W-1:0] LEN_ROW = 3'b111;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  is_write_i,
  input  logic                  single_wr_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o,
  output logic                  reserved_o
);
  logic [COL_W-1:0] raw_mask;
  logic             raw_full;
  logic             clamp;

  always_comb begin
    raw_mask   = '0;
    raw_full   = 1'b0;
    reserved_o = 1'b0;
    case (code_i)
      LEN_1:   raw_mask = '0;
      LEN_2:   raw_mask = COL_W'(1);
      LEN_4:   raw_mask = COL_W'(3);
      LEN_8:   raw_mask = COL_W'(7);
      LEN_ROW: begin
        raw_mask = '1;
        raw_full = 1'b1;
      end
      default: reserved_o = 1'b1;
    endcase
  end

  assign clamp  = is_write_i & single_wr_i;
  assign mask_o = clamp ? '0 : raw_mask;
  assign full_o = raw_full & ~clamp;
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = start_i + beat_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic moved;
    assign moved    = (order_i == ORD_XOR) ? (start_i[i] ^ beat_i[i]) : sum[i];
    assign col_o[i] = mask_i[i] ? moved : start_i[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid_i,
  input  logic                  cmd_write_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  wrap_il_i,
  input  logic                  single_wr_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  col_valid_o,
  output logic                  last_beat_o,
  output logic                  bad_len_o
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // decode of the incoming command
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_rsv;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (len_code_i),
    .is_write_i  (cmd_write_i),
    .single_wr_i (single_wr_i),
    .mask_o      (dec_mask),
    .full_o      (dec_full),
    .reserved_o  (dec_rsv)
  );

  // burst state
  logic             act_q,   act_n;
  logic [COL_W-1:0] start_q, start_n;
  logic [COL_W-1:0] mask_q,  mask_n;
  logic [COL_W-1:0] beat_q,  beat_n;
  logic             full_q,  full_n;
  order_e           ord_q,   ord_n;
  logic             err_q,   err_n;
  logic             at_end;
  logic             burst_en;

  assign at_end   = act_q & ~full_q & (beat_q == mask_q);
  assign burst_en = cmd_valid_i | act_q;

  always_comb begin
    act_n   = act_q;
    start_n = start_q;
    mask_n  = mask_q;
    beat_n  = beat_q;
    full_n  = full_q;
    ord_n   = ord_q;
    err_n   = err_q | (cmd_valid_i & dec_rsv);
    if (cmd_valid_i) begin
      act_n   = 1'b1;
      start_n = start_col_i;
      mask_n  = dec_mask;
      beat_n  = '0;
      full_n  = dec_full;
      ord_n   = (wrap_il_i && !dec_full) ? ORD_XOR : ORD_SEQ;
    end else if (act_q) begin
      if (stop_i || at_end) act_n = 1'b0;
      else                  beat_n = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q   <= 1'b0;
      start_q <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      full_q  <= 1'b0;
      ord_q   <= ORD_SEQ;
    end else if (burst_en) begin
      act_q   <= act_n;
      start_q <= start_n;
      mask_q  <= mask_n;
      beat_q  <= beat_n;
      full_q  <= full_n;
      ord_q   <= ord_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      err_q <= 1'b0;
    else if (cmd_valid_i) err_q <= err_n;
  end

  bcg_addr_calc #(.COL_W(COL_W)) u_calc (
    .start_i (start_q),
    .beat_i  (beat_q),
    .mask_i  (mask_q),
    .order_i (ord_q),
    .col_o   (col_o)
  );

  assign col_valid_o = act_q;
  assign last_beat_o = at_end;
  assign bad_len_o   = err_q;

  // R2
  cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid_i |=> (col_valid_o && col_o == $past(start_col_i)));

  // R3
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_beat_o && !cmd_valid_i) |=> !col_valid_o);

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    col_valid_o |-> (((col_o ^ start_q) & ~mask_q) == '0));

  // R6
  row_no_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && full_q) |-> !last_beat_o);

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop_i && !cmd_valid_i) |=> !col_valid_o);

  // R8
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && cmd_write_i && single_wr_i) |=> last_beat_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_len_o |=> bad_len_o);

  // R1
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last_beat_o |-> col_valid_o);
endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  localparam int COL_W = 8;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid, cmd_write, wrap_il, single_wr, stop;
  logic [COL_W-1:0] start_col;
  logic [2:0]       len_code;
  logic [COL_W-1:0] col;
  logic             col_valid, last_beat, bad_len;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_write_i (cmd_write),
    .start_col_i (start_col),
    .len_code_i  (len_code),
    .wrap_il_i   (wrap_il),
    .single_wr_i (single_wr),
    .stop_i      (stop),
    .col_o       (col),
    .col_valid_o (col_valid),
    .last_beat_o (last_beat),
    .bad_len_o   (bad_len)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state (value after the next edge)
  bit m_act = 0;
  int m_start = 0;
  int m_n = 0;
  int m_len = 1;   // 0 means full row
  bit m_il = 0;
  bit m_err = 0;

  function automatic int ref_len(input int code, input bit wr, input bit sw);
    if (wr && sw) return 1;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_col();
    int lm;
    if (m_len == 0) return (m_start + m_n) % ROW;
    lm = m_len - 1;
    if (m_il) return m_start ^ m_n;
    return (m_start & ~lm) | ((m_start + m_n) & lm);
  endfunction

  function automatic bit ref_last();
    return m_act && m_len != 0 && m_n == m_len - 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "valid", int'(col_valid), int'(m_act));
    check(req, "error", int'(bad_len), int'(m_err));
    if (m_act) begin
      check(req, "column", int'(col), ref_col());
      check(req, "last", int'(last_beat), int'(ref_last()));
    end
  endtask

  // one cycle: check what is due now, then apply inputs and advance the model
  task automatic step(input string req, input bit cv, input bit wr, input int st,
                      input int code, input bit il, input bit sw, input bit sp);
    @(negedge clk);
    compare(req);
    cmd_valid = cv; cmd_write = wr; start_col = COL_W'(st);
    len_code = 3'(code); wrap_il = il; single_wr = sw; stop = sp;
    if (cv) begin
      m_act = 1; m_start = st; m_n = 0;
      m_len = ref_len(code, wr, sw);
      m_il = il && (m_len != 0);
      if (code >= 4 && code <= 6) m_err = 1;
    end else if (m_act) begin
      if (sp || ref_last()) m_act = 0;
      else m_n = (m_n + 1) % ROW;
    end
  endtask

  task automatic idle(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cmd_valid = 0; cmd_write = 0; start_col = '0;
    len_code = '0; wrap_il = 0; single_wr = 0; stop = 0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1;
    idle("R1", 4);

    // R3 / R4: each length, sequential, unaligned start
    for (int c = 0; c < 4; c++) begin
      step("R3", 1, 0, 8'h35, c, 0, 0, 0);
      idle("R4", 10);
    end
    // R5: interleaved, start 1 of 4 gives 1,0,3,2; also 8 from 0x5e
    step("R5", 1, 0, 8'h41, 2, 1, 0, 0);
    idle("R5", 6);
    step("R5", 1, 1, 8'h5e, 3, 1, 0, 0);
    idle("R5", 10);
    // R6: full row with interleave selected, runs past a wrap, then stop
    step("R6", 1, 0, 8'hf0, 7, 1, 0, 0);
    idle("R6", ROW + 20);
    // R7: stop mid burst, and stop with a command on the same edge
    step("R7", 0, 0, 0, 0, 0, 0, 1);
    idle("R7", 2);
    step("R7", 1, 0, 8'h10, 3, 0, 0, 0);
    idle("R7", 2);
    step("R7", 0, 0, 0, 0, 0, 0, 1);
    idle("R7", 2);
    step("R7", 1, 0, 8'h20, 3, 0, 0, 0);
    step("R7", 1, 0, 8'h28, 2, 0, 0, 1);
    idle("R7", 6);
    // R9: back-to-back commands abort the running burst
    step("R9", 1, 0, 8'h80, 3, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 0, 8'h93, 2, 1, 0, 0);
    step("R9", 1, 1, 8'ha7, 1, 0, 0, 0);
    idle("R9", 6);
    // R8: single-write mode clamps writes, reads keep length, full row too
    step("R8", 1, 1, 8'h33, 3, 0, 1, 0);
    idle("R8", 4);
    step("R8", 1, 0, 8'h33, 3, 0, 1, 0);
    idle("R8", 10);
    step("R8", 1, 1, 8'h44, 7, 0, 1, 0);
    idle("R8", 4);
    // R10: reserved code, one beat, sticky flag
    step("R10", 1, 0, 8'h12, 5, 0, 0, 0);
    idle("R10", 4);
    step("R10", 1, 0, 8'h12, 2, 0, 0, 0);
    idle("R10", 6);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit cv, wr, il, sw, sp;
      int code;
      cv   = ($urandom % 5) == 0;
      wr   = $urandom % 2;
      il   = $urandom % 2;
      sw   = ($urandom % 4) == 0;
      sp   = ($urandom % 12) == 0;
      code = (($urandom % 3) == 0) ? 7 : int'($urandom % 8);
      step("R4", cv, wr, int'($urandom % ROW), code, il, sw, sp);
    end
    idle("R3", 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule